// File: doc/BRIEF.md
# Bit Shift, Rotate and Bit-Test Unit

This block is the bit-manipulation slice of a small 8-bit CPU's execute stage. Each clock it can accept one operation: a rotate in either direction (circular or through the carry flag), an arithmetic or logical shift, a nibble swap, or a test, set or clear of one selected bit. The operand byte, the bit index and the current flag byte come from the surrounding datapath. The block returns a result byte, a write-enable that tells the register file or memory stage whether to store that byte, and the new flag byte.

An input qualifier selects the short accumulator rotate forms. These differ from the general rotates only in the zero flag, which they always clear. All outputs are registered. A result appears one clock after its valid-in, and the outputs hold their last values on cycles with no valid-in.

Top module: `bsu_unit`

## Requirements
- R1: While reset is active and after it is released, before any valid-in, out_valid, out_result, out_wr_en and out_flags are all zero.
- R2: out_valid equals in_valid from the previous clock. When in_valid is low, out_result, out_wr_en and out_flags keep their previous values.
- R3: Circular rotates. Op 0 rotates left: bit 7 goes to both C and bit 0. Op 2 rotates right: bit 0 goes to both C and bit 7.
- R4: Rotates through carry. Op 1 moves bit 7 into C and the old C into bit 0. Op 3 moves bit 0 into C and the old C into bit 7.
- R5: Shifts. Op 4 moves bit 7 into C and fills bit 0 with 0. Op 5 keeps bit 7 and moves bit 0 into C. Op 6 fills bit 7 with 0 and moves bit 0 into C.
- R6: Ops 0 to 6 clear N and H and set Z when the result is zero. When in_short_form is 1, ops 0 to 3 force Z to 0. in_short_form has no effect on any other op.
- R7: Op 7 exchanges bits 7:4 with bits 3:0, sets Z when the result is zero, and clears N, H and C.
- R8: Op 8 tests bit in_bit_idx. Z is set when that bit is 0, N is cleared, H is set and C is kept. out_wr_en is 0 and out_result carries the operand unchanged.
- R9: Op 9 forces bit in_bit_idx to 1 and op 10 forces it to 0. Z, N, H and C keep their incoming values.
- R10: In the flag byte, Z is bit 7, N is bit 6, H is bit 5 and C is bit 4. Bits 3:0 of out_flags are always 0. out_wr_en is 1 for ops 0 to 7, 9 and 10.
- R11: Op codes 11 to 15 are reserved. They return the operand unchanged with the incoming Z, N, H and C, and out_wr_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 4 | Operation code (see requirements) |
| in_operand | input | 8 | Operand byte |
| in_bit_idx | input | 3 | Bit index for test, set and clear |
| in_flags | input | 8 | Incoming flag byte |
| in_short_form | input | 1 | Selects the accumulator rotate forms |
| out_valid | output | 1 | Result valid |
| out_result | output | 8 | Result byte |
| out_wr_en | output | 1 | Store the result |
| out_flags | output | 8 | Updated flag byte |

## Verification
The bench builds the unit with its default 8-bit data width and a 3-bit bit index, so every bit position of every op can be reached. Directed sweeps cover all 16 op codes with the operands 0x00, 0x01, 0x80, 0xFF and 0x5A, both carry values and both short-form settings. This reaches zero results, carry-in propagation and forced-zero Z. A random phase follows that inserts idle cycles, so holding across gaps is covered.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  localparam int FLAG_W = 8;
  localparam int FLG_Z = 7;
  localparam int FLG_N = 6;
  localparam int FLG_H = 5;
  localparam int FLG_C = 4;
  localparam logic [FLAG_W-1:0] FLAG_MASK = 8'hF0;

  typedef enum logic [3:0] {
    OP_ROTL   = 4'd0,
    OP_ROTL_C = 4'd1,
    OP_ROTR   = 4'd2,
    OP_ROTR_C = 4'd3,
    OP_SHL_A  = 4'd4,
    OP_SHR_A  = 4'd5,
    OP_SHR_L  = 4'd6,
    OP_NIBSW  = 4'd7,
    OP_TEST   = 4'd8,
    OP_SETB   = 4'd9,
    OP_CLRB   = 4'd10
  } bsu_op_e;
endpackage

// File: rtl/bsu_shift_core.sv
module bsu_shift_core
  import bsu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] operand,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              carry_out
);
  localparam int HALF = DATA_W / 2;
  localparam int MSB  = DATA_W - 1;

  always_comb begin
    result    = operand;
    carry_out = 1'b0;
    case (op)
      OP_ROTL:   begin result = {operand[MSB-1:0], operand[MSB]}; carry_out = operand[MSB]; end
      OP_ROTL_C: begin result = {operand[MSB-1:0], carry_in};     carry_out = operand[MSB]; end
      OP_ROTR:   begin result = {operand[0], operand[MSB:1]};     carry_out = operand[0];   end
      OP_ROTR_C: begin result = {carry_in, operand[MSB:1]};       carry_out = operand[0];   end
      OP_SHL_A:  begin result = {operand[MSB-1:0], 1'b0};         carry_out = operand[MSB]; end
      OP_SHR_A:  begin result = {operand[MSB], operand[MSB:1]};   carry_out = operand[0];   end
      OP_SHR_L:  begin result = {1'b0, operand[MSB:1]};           carry_out = operand[0];   end
      OP_NIBSW:  begin result = {operand[HALF-1:0], operand[MSB:HALF]}; carry_out = 1'b0;   end
      default:   begin result = operand; carry_out = 1'b0; end
    endcase
  end
endmodule

// File: rtl/bsu_bit_core.sv
module bsu_bit_core #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] operand,
  input  logic [IDX_W-1:0]  bit_idx,
  output logic [DATA_W-1:0] set_res,
  output logic [DATA_W-1:0] clr_res,
  output logic              sel_bit
);
  logic [DATA_W-1:0] sel_mask;

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign sel_mask[g] = (bit_idx == IDX_W'(g));
  end

  assign set_res = operand | sel_mask;
  assign clr_res = operand & ~sel_mask;
  assign sel_bit = |(operand & sel_mask);
endmodule

// File: rtl/bsu_flag_merge.sv
module bsu_flag_merge
  import bsu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [3:0]        op,
  input  logic              short_form,
  input  logic [DATA_W-1:0] shift_res,
  input  logic              shift_cy,
  input  logic              sel_bit,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [FLAG_W-1:0] flags_out,
  output logic              wr_en
);
  logic res_zero;
  logic acc_form;

  assign res_zero = (shift_res == '0);
  assign acc_form = short_form && (op <= 4'(OP_ROTR_C));

  always_comb begin
    flags_out = flags_in & FLAG_MASK;
    wr_en     = 1'b1;
    case (op)
      OP_ROTL, OP_ROTL_C, OP_ROTR, OP_ROTR_C,
      OP_SHL_A, OP_SHR_A, OP_SHR_L, OP_NIBSW: begin
        flags_out        = '0;
        flags_out[FLG_Z] = res_zero && !acc_form;
        flags_out[FLG_C] = shift_cy;
      end
      OP_TEST: begin
        flags_out[FLG_Z] = !sel_bit;
        flags_out[FLG_N] = 1'b0;
        flags_out[FLG_H] = 1'b1;
        wr_en            = 1'b0;
      end
      OP_SETB, OP_CLRB: wr_en = 1'b1;
      default:          wr_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/bsu_unit.sv
module bsu_unit
  import bsu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        in_op,
  input  logic [7:0]        in_operand,
  input  logic [2:0]        in_bit_idx,
  input  logic [7:0]        in_flags,
  input  logic              in_short_form,
  output logic              out_valid,
  output logic [7:0]        out_result,
  output logic              out_wr_en,
  output logic [7:0]        out_flags
);
  // reset synchronizer: asserts at once, releases on the clock
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [DATA_W-1:0] shift_res, set_res, clr_res;
  logic              shift_cy, sel_bit;
  logic [FLAG_W-1:0] calc_flags;
  logic              calc_wr;

  bsu_shift_core #(.DATA_W(DATA_W)) u_shift (
    .op(in_op), .operand(in_operand), .carry_in(in_flags[FLG_C]),
    .result(shift_res), .carry_out(shift_cy)
  );

  bsu_bit_core #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bits (
    .operand(in_operand), .bit_idx(in_bit_idx),
    .set_res(set_res), .clr_res(clr_res), .sel_bit(sel_bit)
  );

  bsu_flag_merge #(.DATA_W(DATA_W)) u_flags (
    .op(in_op), .short_form(in_short_form), .shift_res(shift_res),
    .shift_cy(shift_cy), .sel_bit(sel_bit), .flags_in(in_flags),
    .flags_out(calc_flags), .wr_en(calc_wr)
  );

  // next-state
  logic [DATA_W-1:0] calc_res;
  logic              res_en;
  logic              nxt_valid;
  logic [DATA_W-1:0] nxt_result;
  logic              nxt_wr;
  logic [FLAG_W-1:0] nxt_flags;

  always_comb begin
    case (in_op)
      OP_SETB: calc_res = set_res;
      OP_CLRB: calc_res = clr_res;
      default: calc_res = shift_res;
    endcase
  end

  assign res_en     = in_valid;
  assign nxt_valid  = in_valid;
  assign nxt_result = calc_res;
  assign nxt_wr     = calc_wr;
  assign nxt_flags  = calc_flags;

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= nxt_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_result <= '0;
      out_wr_en  <= 1'b0;
      out_flags  <= '0;
    end else if (res_en) begin
      out_result <= nxt_result;
      out_wr_en  <= nxt_wr;
      out_flags  <= nxt_flags;
    end
  end
endmodule

// File: rtl/bsu_unit_chk.sv
module bsu_unit_chk (
  input logic       clk,
  input logic       rst_ok,
  input logic       in_valid,
  input logic [3:0] in_op,
  input logic [7:0] in_flags,
  input logic       in_short_form,
  input logic       out_valid,
  input logic [7:0] out_result,
  input logic       out_wr_en,
  input logic [7:0] out_flags
);
  // R10
  flag_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    out_valid |-> (out_flags[3:0] == 4'h0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_flags) && $stable(out_wr_en)));

  // R8
  test_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && in_op == 4'd8) |=> (out_valid && !out_wr_en && out_flags[4] == $past(in_flags[4])
                                     && out_flags[5] && !out_flags[6]));

  // R9
  setclr_flags_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && (in_op == 4'd9 || in_op == 4'd10)) |=>
      (out_wr_en && out_flags == {$past(in_flags[7:4]), 4'h0}));

  // R6
  short_rot_z_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && in_short_form && in_op <= 4'd3) |=> !out_flags[7]);

  // R6
  shift_nh_clear_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && in_op <= 4'd7) |=> (out_wr_en && out_flags[6:5] == 2'b00));
endmodule

bind bsu_unit bsu_unit_chk u_chk (
  .clk(clk), .rst_ok(rst_sync_n), .in_valid(in_valid), .in_op(in_op),
  .in_flags(in_flags), .in_short_form(in_short_form), .out_valid(out_valid),
  .out_result(out_result), .out_wr_en(out_wr_en), .out_flags(out_flags)
);

// File: tb/bsu_unit_tb.sv
module bsu_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [3:0] in_op;
  logic [7:0] in_operand;
  logic [2:0] in_bit_idx;
  logic [7:0] in_flags;
  logic       in_short_form;
  logic       out_valid;
  logic [7:0] out_result;
  logic       out_wr_en;
  logic [7:0] out_flags;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // expected registered state
  logic       e_valid;
  logic [7:0] e_result;
  logic       e_wr;
  logic [7:0] e_flags;
  string      e_tag;

  always #4 clk = ~clk;

  bsu_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_operand(in_operand), .in_bit_idx(in_bit_idx), .in_flags(in_flags),
    .in_short_form(in_short_form), .out_valid(out_valid), .out_result(out_result),
    .out_wr_en(out_wr_en), .out_flags(out_flags)
  );

  function automatic string req_of(int op);
    case (op)
      0, 2: return "R3";
      1, 3: return "R4";
      4, 5, 6: return "R5";
      7: return "R7";
      8: return "R8";
      9, 10: return "R9";
      default: return "R11";
    endcase
  endfunction

  // behavioural model: returns {wr, flags, result}
  task automatic model(input int op, input int a, input int idx, input int fl, input bit sh,
                       output logic [7:0] r, output logic w, output logic [7:0] f);
    int res, c, z, n, h, cin;
    cin = (fl >> 4) & 1;
    res = a; c = cin; n = (fl >> 6) & 1; h = (fl >> 5) & 1; z = (fl >> 7) & 1;
    w = 1;
    if (op <= 6) begin
      case (op)
        0: begin c = a / 128; res = (a * 2) % 256 + c; end
        1: begin c = a / 128; res = (a * 2) % 256 + cin; end
        2: begin c = a % 2; res = a / 2 + c * 128; end
        3: begin c = a % 2; res = a / 2 + cin * 128; end
        4: begin c = a / 128; res = (a * 2) % 256; end
        5: begin c = a % 2; res = a / 2 + (a / 128) * 128; end
        default: begin c = a % 2; res = a / 2; end
      endcase
      n = 0; h = 0;
      z = (res == 0 && !(sh && op <= 3)) ? 1 : 0;
    end else if (op == 7) begin
      res = (a % 16) * 16 + a / 16;
      z = (res == 0) ? 1 : 0; n = 0; h = 0; c = 0;
    end else if (op == 8) begin
      z = ((a >> idx) & 1) ? 0 : 1; n = 0; h = 1; w = 0;
    end else if (op == 9) begin
      res = a | (1 << idx);
    end else if (op == 10) begin
      res = a & ~(1 << idx) & 255;
    end else begin
      w = 0;
    end
    r = res[7:0];
    f = {z[0], n[0], h[0], c[0], 4'h0};
  endtask

  task automatic compare();
    total++;
    if (out_valid !== e_valid || out_result !== e_result || out_wr_en !== e_wr || out_flags !== e_flags) begin
      bad++;
      $display("FAIL %s: got v=%0b r=%02h w=%0b f=%02h expected v=%0b r=%02h w=%0b f=%02h",
               e_tag, out_valid, out_result, out_wr_en, out_flags,
               e_valid, e_result, e_wr, e_flags);
    end
  endtask

  task automatic step(input bit v, input int op, input int a, input int idx, input int fl, input bit sh);
    @(negedge clk);
    compare();
    in_valid = v; in_op = op[3:0]; in_operand = a[7:0]; in_bit_idx = idx[2:0];
    in_flags = fl[7:0]; in_short_form = sh;
    if (v) begin
      model(op, a, idx, fl, sh, e_result, e_wr, e_flags);
      e_valid = 1'b1;
      e_tag = (op <= 3 && sh) ? {req_of(op), "/R6"} : {req_of(op), "/R10"};
    end else begin
      e_valid = 1'b0;
      e_tag = "R2 hold";
    end
  endtask

  initial begin
    int pats[5] = '{8'h00, 8'h01, 8'h80, 8'hFF, 8'h5A};
    rst_n = 1'b0; in_valid = 0; in_op = 0; in_operand = 0; in_bit_idx = 0;
    in_flags = 0; in_short_form = 0;
    e_valid = 0; e_result = 0; e_wr = 0; e_flags = 0; e_tag = "R1 reset";
    repeat (3) @(negedge clk);
    compare();  // R1 during reset
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare();  // R1 after release
    e_tag = "R1 reset";
    // directed sweep of every op, pattern, carry and short-form value
    for (int op = 0; op < 16; op++)
      for (int p = 0; p < 5; p++)
        for (int cy = 0; cy < 2; cy++)
          for (int sh = 0; sh < 2; sh++)
            step(1'b1, op, pats[p], (p * 3 + cy) % 8, cy ? 8'hFF : 8'h0F, sh[0]);
    // every bit index for test, set and clear (R8, R9)
    for (int op = 8; op < 11; op++)
      for (int i = 0; i < 8; i++) begin
        step(1'b1, op, 8'hA5, i, 8'h50, 1'b0);
        step(1'b1, op, 8'h5A, i, 8'hA0, 1'b1);
      end
    // R2: idle gap holds the last result
    step(1'b1, 4, 8'hC3, 0, 8'h00, 1'b0);
    step(1'b0, 0, 8'h00, 0, 8'hFF, 1'b1);
    step(1'b0, 9, 8'h11, 2, 8'h00, 1'b0);
    // random traffic with idle cycles
    for (int k = 0; k < 3000; k++)
      step(($urandom % 4) != 0, $urandom % 16, $urandom % 256, $urandom % 8,
           $urandom % 256, $urandom % 2);
    step(1'b0, 0, 0, 0, 0, 1'b0);
    step(1'b0, 0, 0, 0, 0, 1'b0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule